// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital timing controller of a dual-slope integrating converter. It moves each conversion through three phases in a fixed order. First comes auto-zero. Next is a signal integrate of fixed length. Last is a de-integrate of variable length, during which the block counts clocks until the external comparator flips.

Every conversion occupies a frame of constant length. Auto-zero absorbs whatever time the de-integrate did not use. The converted value is a magnitude count, a sign bit and an over-range flag. It is captured into output registers and announced with a single-cycle strobe.

The analog switches, the integrator and the comparator sit outside the block. They are seen only as a one-hot phase-select output and a single comparator input bit. A run/hold input decides whether conversions repeat. When it is low, the current conversion still finishes. The sequencer then parks in auto-zero a few clocks before the next integrate would begin.

Top module: `dual_slope_sequencer`

## Requirements
- R1: While `rst` is high and after it falls, until the first integrate, `phase_sel` is 3'b001 (auto-zero). `status`, `data_valid`, `res_mag`, `res_pol` and `res_ovr` are all zero. Auto-zero after reset lasts FRAME_LEN-INT_LEN-2^CNT_W clocks, which is 2048 with the defaults.
- R2: The integrate phase (`phase_sel` = 3'b010) always lasts exactly INT_LEN clocks (2048) and is always followed directly by de-integrate (`phase_sel` = 3'b100).
- R3: With `run_hold` high, integrate starts exactly every FRAME_LEN clocks (8192), whatever the de-integrate length was.
- R4: `res_mag` is the number of de-integrate clocks completed before the first clock on which `cmp_in` differs from the sampled polarity. A flip on the very first de-integrate clock gives 0.
- R5: `res_pol` is the value of `cmp_in` on the last integrate clock (1 means a positive input).
- R6: If `cmp_in` has not flipped by de-integrate count 2^CNT_W-1 (4095), de-integrate ends with `res_mag` = 4095 and `res_ovr` = 1. A flip at exactly count 4095 gives `res_mag` = 4095 and `res_ovr` = 0.
- R7: `phase_sel` is always one-hot. `status` is high exactly while `phase_sel` is integrate or de-integrate, and low in auto-zero.
- R8: `data_valid` is high for one clock, in the first auto-zero cycle after de-integrate ends, together with the new result. The result outputs do not change in any other cycle.
- R9: With `run_hold` low, the sequencer stops in auto-zero PARK_LEAD (7) clocks before integrate. It stays there without starting a new conversion. The clock edge that first sees `run_hold` high starts a count, and integrate begins on the 7th such edge.
- R10: Lowering `run_hold` during integrate or de-integrate does not cut the conversion short: the result is still latched with its correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| run_hold | input | 1 | 1 = convert continuously, 0 = finish and park |
| cmp_in | input | 1 | Comparator output: integrator sign |
| phase_sel | output | 3 | One-hot phase: bit0 auto-zero, bit1 integrate, bit2 de-integrate |
| status | output | 1 | High during integrate and de-integrate |
| data_valid | output | 1 | One-clock pulse when a new result is latched |
| res_mag | output | CNT_W | Latched magnitude count |
| res_pol | output | 1 | Latched polarity, 1 = positive |
| res_ovr | output | 1 | Latched over-range flag |

## Verification
The comparator flip and the count limit can land on the same de-integrate clock. The bench provokes this by making the comparator flip at exactly count 4095. The correct outcome is a full-scale magnitude with the over-range flag clear, while a flip one count later must set the flag.

The release of `run_hold` and the park point can also meet. The bench holds the sequencer parked for thousands of clocks, raises the input, and requires integrate on exactly the seventh edge. A behavioural reference model is compared against every output on every clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_e;

    localparam int SEL_W = 3;

    function automatic logic [SEL_W-1:0] phase_onehot(input phase_e ph);
        logic [SEL_W-1:0] sel;
        sel = '0;
        case (ph)
            PH_INT:   sel[1] = 1'b1;
            PH_DEINT: sel[2] = 1'b1;
            default:  sel[0] = 1'b1;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/dsc_frame_timer.sv
module dsc_frame_timer #(
    parameter int FRAME_LEN = 8192,
    parameter int INT_LEN   = 2048,
    parameter int PARK_LEAD = 7,
    parameter int AZ_START  = 6144,
    parameter int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic run_hold,
    output logic frame_last,
    output logic int_last
);
    localparam int PARK_POS = FRAME_LEN - PARK_LEAD;

    logic [POS_W-1:0] pos_q;
    logic             parked;

    assign frame_last = (pos_q == POS_W'(FRAME_LEN - 1));
    assign int_last   = (pos_q == POS_W'(INT_LEN - 1));
    assign parked     = (pos_q == POS_W'(PARK_POS)) && !run_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_W'(AZ_START);
        end else if (!parked) begin
            pos_q <= frame_last ? '0 : pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/dsc_phase_fsm.sv
module dsc_phase_fsm
    import dsc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_last,
    input  logic             int_last,
    input  logic             cmp_in,
    output phase_e           phase,
    output logic [CNT_W-1:0] dcnt,
    output logic             pol_seen,
    output logic             crossed,
    output logic             latch_stb
);
    localparam logic [CNT_W-1:0] DCNT_MAX = '1;

    phase_e phase_q;

    assign phase     = phase_q;
    assign crossed   = cmp_in ^ pol_seen;
    assign latch_stb = (phase_q == PH_DEINT) && (crossed || dcnt == DCNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_AZ;
            dcnt     <= '0;
            pol_seen <= 1'b0;
        end else begin
            case (phase_q)
                PH_AZ: begin
                    if (frame_last) phase_q <= PH_INT;
                end
                PH_INT: begin
                    if (int_last) begin
                        phase_q  <= PH_DEINT;
                        dcnt     <= '0;
                        pol_seen <= cmp_in;
                    end
                end
                PH_DEINT: begin
                    if (latch_stb) phase_q <= PH_AZ;
                    else           dcnt    <= dcnt + 1'b1;
                end
                default: phase_q <= PH_AZ;
            endcase
        end
    end

endmodule

// File: rtl/dsc_result_latch.sv
module dsc_result_latch #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_stb,
    input  logic [CNT_W-1:0] dcnt,
    input  logic             pol_seen,
    input  logic             crossed,
    output logic [CNT_W-1:0] res_mag,
    output logic             res_pol,
    output logic             res_ovr,
    output logic             data_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_mag    <= '0;
            res_pol    <= 1'b0;
            res_ovr    <= 1'b0;
            data_valid <= 1'b0;
        end else begin
            data_valid <= latch_stb;
            if (latch_stb) begin
                res_mag <= dcnt;
                res_pol <= pol_seen;
                res_ovr <= !crossed;
            end
        end
    end

endmodule

// File: rtl/dual_slope_sequencer.sv
module dual_slope_sequencer
    import dsc_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int INT_LEN   = 2048,
    parameter int FRAME_LEN = 8192,
    parameter int PARK_LEAD = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_hold,
    input  logic             cmp_in,
    output logic [2:0]       phase_sel,
    output logic             status,
    output logic             data_valid,
    output logic [CNT_W-1:0] res_mag,
    output logic             res_pol,
    output logic             res_ovr
);
    localparam int POS_W    = $clog2(FRAME_LEN);
    localparam int AZ_START = INT_LEN + (1 << CNT_W);

    logic             frame_last;
    logic             int_last;
    phase_e           phase;
    logic [CNT_W-1:0] dcnt;
    logic             pol_seen;
    logic             crossed;
    logic             latch_stb;

    dsc_frame_timer #(
        .FRAME_LEN(FRAME_LEN),
        .INT_LEN  (INT_LEN),
        .PARK_LEAD(PARK_LEAD),
        .AZ_START (AZ_START),
        .POS_W    (POS_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_hold  (run_hold),
        .frame_last(frame_last),
        .int_last  (int_last)
    );

    dsc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .frame_last(frame_last),
        .int_last  (int_last),
        .cmp_in    (cmp_in),
        .phase     (phase),
        .dcnt      (dcnt),
        .pol_seen  (pol_seen),
        .crossed   (crossed),
        .latch_stb (latch_stb)
    );

    dsc_result_latch #(.CNT_W(CNT_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .latch_stb (latch_stb),
        .dcnt      (dcnt),
        .pol_seen  (pol_seen),
        .crossed   (crossed),
        .res_mag   (res_mag),
        .res_pol   (res_pol),
        .res_ovr   (res_ovr),
        .data_valid(data_valid)
    );

    assign phase_sel = phase_onehot(phase);
    assign status    = (phase != PH_AZ);

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int CNT_W   = 12,
    parameter int INT_LEN = 2048
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       phase_sel,
    input logic             status,
    input logic             data_valid,
    input logic [CNT_W-1:0] res_mag,
    input logic             res_pol,
    input logic             res_ovr
);
    int int_run;

    always_ff @(posedge clk) begin
        if (rst)               int_run <= 0;
        else if (phase_sel[1]) int_run <= int_run + 1;
        else                   int_run <= 0;
    end

    // R7: phase select is one-hot
    assert_onehot_phase_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_sel) == 1);

    // R7: status low whenever auto-zero is selected
    assert_status_az_R7: assert property (@(posedge clk) disable iff (rst)
        phase_sel[0] |-> !status);

    // R2: integrate never runs past its fixed length
    assert_int_bound_R2: assert property (@(posedge clk) disable iff (rst)
        phase_sel[1] |-> int_run < INT_LEN);

    // R2: integrate ends after exactly INT_LEN clocks and hands over to de-integrate
    assert_int_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_sel[1]) |-> (int_run == INT_LEN) && phase_sel[2]);

    // R8: data_valid is a single-cycle pulse in auto-zero
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> !data_valid);

    assert_valid_az_R8: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> phase_sel[0] && $past(phase_sel[2]));

    // R8: results hold between strobes
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !data_valid |-> $stable(res_mag) && $stable(res_pol) && $stable(res_ovr));

    // R6: over-range always comes with a saturated magnitude
    assert_ovr_sat_R6: assert property (@(posedge clk) disable iff (rst)
        res_ovr |-> (&res_mag));

endmodule

bind dual_slope_sequencer dsc_checker #(
    .CNT_W  (CNT_W),
    .INT_LEN(INT_LEN)
) u_dsc_checker (
    .clk       (clk),
    .rst       (rst),
    .phase_sel (phase_sel),
    .status    (status),
    .data_valid(data_valid),
    .res_mag   (res_mag),
    .res_pol   (res_pol),
    .res_ovr   (res_ovr)
);

// File: tb/dual_slope_sequencer_bench.sv
`timescale 1ns/1ps
module dual_slope_sequencer_bench;

    localparam int FRAME = 8192;
    localparam int INTL  = 2048;
    localparam int MAXC  = 4095;
    localparam int PARKP = FRAME - 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_hold = 1'b1;
    logic        cmp_in = 1'b0;
    logic [2:0]  phase_sel;
    logic        status;
    logic        data_valid;
    logic [11:0] res_mag;
    logic        res_pol;
    logic        res_ovr;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;

    // stimulus control for the comparator
    int want_cnt = 100;
    bit want_pol = 1'b1;
    int dk = 0;

    // reference model state
    int  m_pos = INTL + MAXC + 1;
    int  m_ph = 0;
    int  m_d = 0;
    bit  m_sp = 0;
    int  m_mag = 0;
    bit  m_pol = 0;
    bit  m_ovr = 0;
    bit  m_val = 0;

    always #2.5 clk = ~clk;

    dual_slope_sequencer u_dual_slope_sequencer (
        .clk(clk), .rst(rst), .run_hold(run_hold), .cmp_in(cmp_in),
        .phase_sel(phase_sel), .status(status), .data_valid(data_valid),
        .res_mag(res_mag), .res_pol(res_pol), .res_ovr(res_ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            m_pos = INTL + MAXC + 1; m_ph = 0; m_d = 0; m_sp = 0;
            m_mag = 0; m_pol = 0; m_ovr = 0; m_val = 0;
        end else begin
            m_val = 0;
            if (m_ph == 0) begin
                if (m_pos == PARKP && !run_hold) begin
                    // parked
                end else if (m_pos == FRAME - 1) begin
                    m_ph = 1; m_pos = 0;
                end else m_pos++;
            end else if (m_ph == 1) begin
                if (m_pos == INTL - 1) begin
                    m_ph = 2; m_d = 0; m_sp = cmp_in;
                end
                m_pos++;
            end else begin
                if ((cmp_in != m_sp) || m_d == MAXC) begin
                    m_mag = m_d; m_ovr = (cmp_in == m_sp); m_pol = m_sp;
                    m_val = 1; m_ph = 0;
                end else m_d++;
                m_pos++;
            end
        end
    end

    // per-cycle comparison and comparator drive, away from the rising edge
    always @(negedge clk) begin
        logic [2:0] exp_sel;
        if (started && !done) begin
            exp_sel = (m_ph == 0) ? 3'b001 : (m_ph == 1) ? 3'b010 : 3'b100;
            chk(phase_sel == exp_sel, "R3 phase", int'(phase_sel), int'(exp_sel));
            chk(status == (m_ph != 0), "R7 status", int'(status), int'(m_ph != 0));
            chk(data_valid == m_val, "R8 valid", int'(data_valid), int'(m_val));
            chk(res_mag == 12'(m_mag), "R4 mag", int'(res_mag), m_mag);
            chk(res_pol == m_pol, "R5 pol", int'(res_pol), int'(m_pol));
            chk(res_ovr == m_ovr, "R6 ovr", int'(res_ovr), int'(m_ovr));
        end
        if (phase_sel == 3'b100) begin
            cmp_in <= (dk >= want_cnt) ? ~want_pol : want_pol;
            dk++;
        end else begin
            cmp_in <= want_pol;
            dk = 0;
        end
    end

    task automatic wait_valid();
        do @(negedge clk); while (data_valid !== 1'b1);
    endtask

    task automatic run_case(input bit p, input int n, input string req);
        int emag;
        want_pol = p; want_cnt = n;
        wait_valid();
        emag = (n > MAXC) ? MAXC : n;
        chk(res_mag == 12'(emag), req, int'(res_mag), emag);
        chk(res_ovr == (n > MAXC), req, int'(res_ovr), int'(n > MAXC));
        chk(res_pol == p, "R5", int'(res_pol), int'(p));
    endtask

    int t_int_prev = -1;
    always @(negedge clk) begin
        if (!rst && run_hold && phase_sel == 3'b010 && status && $past(phase_sel) == 3'b001) begin
            if (t_int_prev >= 0)
                chk(cyc - t_int_prev == FRAME, "R3 frame", cyc - t_int_prev, FRAME);
            t_int_prev = cyc;
        end
    end

    initial begin
        int waited;
        int k;
        repeat (3) @(negedge clk);
        chk(phase_sel == 3'b001, "R1 phase", int'(phase_sel), 1);
        chk({status, data_valid, res_pol, res_ovr} == 4'b0 && res_mag == 0, "R1 regs",
            int'(res_mag), 0);
        rst = 1'b0;
        // reset auto-zero length
        waited = 0;
        do begin @(negedge clk); waited++; end while (phase_sel != 3'b010);
        chk(waited == FRAME - INTL - MAXC - 1, "R1 az", waited, FRAME - INTL - MAXC - 1);

        run_case(1'b1, 100, "R4");
        run_case(1'b0, 0, "R4 zero");
        run_case(1'b1, MAXC, "R6 edge");
        run_case(1'b0, MAXC + 1, "R6 over");
        run_case(1'b1, 2047, "R4");

        // hold during integrate: conversion still completes
        want_pol = 1'b0; want_cnt = 500;
        do @(negedge clk); while (phase_sel != 3'b010);
        run_hold = 1'b0;
        t_int_prev = -1;
        wait_valid();
        chk(res_mag == 500 && !res_ovr, "R10", int'(res_mag), 500);

        // parked: no integrate for a long time
        k = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (phase_sel != 3'b001) k++;
        end
        chk(k == 0, "R9 park", k, 0);

        // release and count edges to integrate
        run_hold = 1'b1;
        waited = 0;
        do begin @(negedge clk); waited++; end while (phase_sel != 3'b010 && waited < 100);
        chk(waited == 7, "R9 resume", waited, 7);

        run_case(1'b1, 1234, "R4");
        run_case(1'b0, 3000, "R4");

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule